// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Aggregator

This block collects completion events from a multichannel DMA engine and turns them into one level interrupt for the host. Events arrive in three independent groups: transmit channels, receive channels and DMA error conditions. Each channel drives a one-cycle completion pulse, which latches a raw status bit. The channel later drives an acknowledge pulse, which clears that bit.

Software sees each group through four 32-bit registers on a simple read/write port: raw status, masked status, mask-set and mask-clear. Mask bits change only through write-one-to-set and write-one-to-clear strobes, so no read-modify-write sequence is ever needed. One combined interrupt line is high while any enabled source is pending. A write to the end-of-interrupt address drops that line for one cycle, so a source that is still pending raises a fresh edge.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every raw status and mask bit is 0, `irq_out` is 0, and every register reads 0.
- R2: Register addresses are as follows. The transmit group is based at 0x80, the receive group at 0xA0 and the error group at 0xB0. Within a group, base+0x0 is raw status, base+0x4 is masked status, base+0x8 is mask-set and base+0xC is mask-clear. An unmapped address reads 0, and reads are combinational from `reg_addr`.
- R3: A completion pulse on channel i sets raw bit i of its group. The bit is visible on the cycle after the pulse.
- R4: An acknowledge pulse on channel i clears raw bit i. If a completion pulse and an acknowledge pulse arrive on the same channel in the same cycle, the bit ends up set.
- R5: A write to a mask-set address sets the mask bits written as 1 and leaves the bits written as 0 unchanged. Reading either the mask-set or the mask-clear address returns the current mask.
- R6: A write to a mask-clear address clears the mask bits written as 1. Writing all ones clears the whole group's mask at once.
- R7: Masked status reads as raw status AND mask, with no added cycle of latency.
- R8: `irq_out` is 1 exactly when at least one masked bit is set in any group. The only exception is the end-of-interrupt gap described in R9.
- R9: A write of any value to 0x94 forces `irq_out` to 0 for the single cycle after the write. After that cycle, `irq_out` follows R8 again.
- R10: Address 0x90 reads a pending vector, with bit 0 for transmit, bit 1 for receive and bit 2 for error. A bit is 1 when its group has any masked bit set. Writes to the raw, masked and vector addresses change nothing.
- R11: The host-error condition is error-group source 1. It uses raw, mask and masked bit 1 of the group based at 0xB0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte address, used for both reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tx_done | input | NUM_CH | Transmit channel completion pulses |
| tx_ack | input | NUM_CH | Transmit channel acknowledge pulses |
| rx_done | input | NUM_CH | Receive channel completion pulses |
| rx_ack | input | NUM_CH | Receive channel acknowledge pulses |
| err_done | input | NUM_ERR | Error condition pulses; bit 1 is the host error |
| err_ack | input | NUM_ERR | Error condition acknowledge pulses |
| irq_out | output | 1 | Combined interrupt level |

## Verification
The properties rely on three assumptions about the inputs:
- `reg_wr` is a single-cycle strobe whose address is stable in the cycle it is sampled.
- Pulse inputs change only between clock edges.
- Each write targets exactly one address.

The bench meets these assumptions by driving every input one time unit after a rising edge. It issues writes one per cycle and returns the strobe to 0 afterwards. It also clears each pulse vector on the cycle after raising it, so no write and no read ever overlap.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned N_GROUPS = 3;
   localparam logic [7:0] TX_BASE  = 8'h80;
   localparam logic [7:0] RX_BASE  = 8'hA0;
   localparam logic [7:0] ERR_BASE = 8'hB0;
   localparam logic [7:0] OFS_RAW  = 8'h0;
   localparam logic [7:0] OFS_MSKD = 8'h4;
   localparam logic [7:0] OFS_SET  = 8'h8;
   localparam logic [7:0] OFS_CLR  = 8'hC;
   localparam logic [7:0] VEC_ADDR = 8'h90;
   localparam logic [7:0] EOI_ADDR = 8'h94;
   localparam int unsigned HOST_ERR_BIT = 1;

   typedef enum logic [1:0] {GRP_TX = 2'd0, GRP_RX = 2'd1, GRP_ERR = 2'd2} grp_e;

   function automatic logic [7:0] grp_base(input int unsigned g);
      case (g)
         0:       return TX_BASE;
         1:       return RX_BASE;
         default: return ERR_BASE;
      endcase
   endfunction
endpackage

// File: rtl/irq_group.sv
module irq_group #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] done,
   input  logic [W-1:0] ack,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wbits,
   output logic [W-1:0] raw,
   output logic [W-1:0] mask,
   output logic [W-1:0] masked,
   output logic         pending
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       raw[i] <= 1'b0;
         else if (done[i]) raw[i] <= 1'b1;
         else if (ack[i])  raw[i] <= 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  mask[i] <= 1'b0;
         else if (set_we && wbits[i]) mask[i] <= 1'b1;
         else if (clr_we && wbits[i]) mask[i] <= 1'b0;
      end
   end

   assign masked  = raw & mask;
   assign pending = |masked;
endmodule

// File: rtl/irq_regdec.sv
module irq_regdec
   import dma_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]                       addr,
   input  logic                                    wr,
   input  logic [N_GROUPS-1:0][DATA_W-1:0]         raw_w,
   input  logic [N_GROUPS-1:0][DATA_W-1:0]         mask_w,
   input  logic [N_GROUPS-1:0][DATA_W-1:0]         mskd_w,
   input  logic [N_GROUPS-1:0]                     pend,
   output logic [N_GROUPS-1:0]                     set_we,
   output logic [N_GROUPS-1:0]                     clr_we,
   output logic                                    eoi_we,
   output logic [DATA_W-1:0]                       rdata
);
   logic [N_GROUPS-1:0][DATA_W-1:0] grp_rd;
   logic [N_GROUPS-1:0]             grp_hit;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(grp_base(g) + OFS_RAW);
      localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(grp_base(g) + OFS_MSKD);
      localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(grp_base(g) + OFS_SET);
      localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(grp_base(g) + OFS_CLR);

      assign set_we[g] = wr && (addr == A_SET);
      assign clr_we[g] = wr && (addr == A_CLR);

      always_comb begin
         grp_hit[g] = 1'b1;
         if      (addr == A_RAW)                    grp_rd[g] = raw_w[g];
         else if (addr == A_MSKD)                   grp_rd[g] = mskd_w[g];
         else if (addr == A_SET || addr == A_CLR)   grp_rd[g] = mask_w[g];
         else begin
            grp_hit[g] = 1'b0;
            grp_rd[g]  = '0;
         end
      end
   end

   assign eoi_we = wr && (addr == ADDR_W'(EOI_ADDR));

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(VEC_ADDR)) rdata[N_GROUPS-1:0] = pend;
      for (int g = 0; g < N_GROUPS; g++)
         if (grp_hit[g]) rdata = grp_rd[g];
   end
endmodule

// File: rtl/irq_eoi_ctl.sv
module irq_eoi_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic eoi_we,
   input  logic any_pending,
   output logic irq
);
   logic gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= 1'b0;
      else        gap_q <= eoi_we;
   end

   assign irq = any_pending && !gap_q;
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned NUM_ERR = 2,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_CH-1:0]  tx_done,
   input  logic [NUM_CH-1:0]  tx_ack,
   input  logic [NUM_CH-1:0]  rx_done,
   input  logic [NUM_CH-1:0]  rx_ack,
   input  logic [NUM_ERR-1:0] err_done,
   input  logic [NUM_ERR-1:0] err_ack,
   output logic               irq_out
);
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie in 1..32");
   end
   if (NUM_ERR <= HOST_ERR_BIT || NUM_ERR > DATA_W) begin : g_bad_err
      $error("NUM_ERR must cover the host-error bit and fit 32 bits");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic [NUM_CH-1:0]  tx_raw, tx_mask, tx_mskd;
   logic [NUM_CH-1:0]  rx_raw, rx_mask, rx_mskd;
   logic [NUM_ERR-1:0] er_raw, er_mask, er_mskd;
   logic [N_GROUPS-1:0] set_we, clr_we, pend;
   logic                eoi_we;
   logic [N_GROUPS-1:0][DATA_W-1:0] raw_w, mask_w, mskd_w;

   irq_group #(.W(NUM_CH)) u_tx (
      .clk(clk), .rst_n(rst_n), .done(tx_done), .ack(tx_ack),
      .set_we(set_we[GRP_TX]), .clr_we(clr_we[GRP_TX]),
      .wbits(reg_wdata[NUM_CH-1:0]),
      .raw(tx_raw), .mask(tx_mask), .masked(tx_mskd), .pending(pend[GRP_TX]));

   irq_group #(.W(NUM_CH)) u_rx (
      .clk(clk), .rst_n(rst_n), .done(rx_done), .ack(rx_ack),
      .set_we(set_we[GRP_RX]), .clr_we(clr_we[GRP_RX]),
      .wbits(reg_wdata[NUM_CH-1:0]),
      .raw(rx_raw), .mask(rx_mask), .masked(rx_mskd), .pending(pend[GRP_RX]));

   irq_group #(.W(NUM_ERR)) u_err (
      .clk(clk), .rst_n(rst_n), .done(err_done), .ack(err_ack),
      .set_we(set_we[GRP_ERR]), .clr_we(clr_we[GRP_ERR]),
      .wbits(reg_wdata[NUM_ERR-1:0]),
      .raw(er_raw), .mask(er_mask), .masked(er_mskd), .pending(pend[GRP_ERR]));

   always_comb begin
      raw_w  = '0;
      mask_w = '0;
      mskd_w = '0;
      raw_w[GRP_TX][NUM_CH-1:0]    = tx_raw;
      mask_w[GRP_TX][NUM_CH-1:0]   = tx_mask;
      mskd_w[GRP_TX][NUM_CH-1:0]   = tx_mskd;
      raw_w[GRP_RX][NUM_CH-1:0]    = rx_raw;
      mask_w[GRP_RX][NUM_CH-1:0]   = rx_mask;
      mskd_w[GRP_RX][NUM_CH-1:0]   = rx_mskd;
      raw_w[GRP_ERR][NUM_ERR-1:0]  = er_raw;
      mask_w[GRP_ERR][NUM_ERR-1:0] = er_mask;
      mskd_w[GRP_ERR][NUM_ERR-1:0] = er_mskd;
   end

   irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(reg_addr), .wr(reg_wr), .raw_w(raw_w), .mask_w(mask_w),
      .mskd_w(mskd_w), .pend(pend), .set_we(set_we), .clr_we(clr_we),
      .eoi_we(eoi_we), .rdata(reg_rdata));

   irq_eoi_ctl u_eoi (
      .clk(clk), .rst_n(rst_n), .eoi_we(eoi_we),
      .any_pending(|pend), .irq(irq_out));
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned NUM_ERR = 2,
   parameter int unsigned ADDR_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_wr,
   input logic [NUM_CH-1:0]  wd_lo,
   input logic [NUM_CH-1:0]  tx_done,
   input logic [NUM_CH-1:0]  tx_ack,
   input logic [NUM_CH-1:0]  tx_raw,
   input logic [NUM_CH-1:0]  tx_mask,
   input logic [NUM_CH-1:0]  rx_raw,
   input logic [NUM_CH-1:0]  rx_mask,
   input logic [NUM_ERR-1:0] er_raw,
   input logic [NUM_ERR-1:0] er_mask,
   input logic               irq_out
);
   logic eoi_wr, tx_set_wr, tx_clr_wr, any_on;
   assign eoi_wr    = reg_wr && (reg_addr == ADDR_W'(EOI_ADDR));
   assign tx_set_wr = reg_wr && (reg_addr == ADDR_W'(TX_BASE + OFS_SET));
   assign tx_clr_wr = reg_wr && (reg_addr == ADDR_W'(TX_BASE + OFS_CLR));
   assign any_on    = |(tx_raw & tx_mask) || |(rx_raw & rx_mask) || |(er_raw & er_mask);

   p_done_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_done) |=> ((tx_raw & $past(tx_done)) == $past(tx_done)));

   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(tx_ack & ~tx_done)) |=> ((tx_raw & $past(tx_ack & ~tx_done)) == '0));

   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_set_wr |=> ((tx_mask & $past(wd_lo)) == $past(wd_lo)));

   p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr_wr |=> ((tx_mask & $past(wd_lo)) == '0));

   p_eoi_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr |=> !irq_out);

   p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (any_on && !$past(eoi_wr)) |-> irq_out);

   p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !any_on |-> !irq_out);
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_CH(NUM_CH), .NUM_ERR(NUM_ERR), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .wd_lo(reg_wdata[NUM_CH-1:0]), .tx_done(tx_done), .tx_ack(tx_ack),
   .tx_raw(tx_raw), .tx_mask(tx_mask), .rx_raw(rx_raw), .rx_mask(rx_mask),
   .er_raw(er_raw), .er_mask(er_mask), .irq_out(irq_out));

// File: tb/dma_irq_agg_bench.sv
`timescale 1ns/1ps
module dma_irq_agg_bench;
   localparam int NCH = 8;
   localparam int NER = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      reg_addr = '0;
   logic            reg_wr = 1'b0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NCH-1:0]  tx_done = '0, tx_ack = '0, rx_done = '0, rx_ack = '0;
   logic [NER-1:0]  err_done = '0, err_ack = '0;
   logic            irq_out;

   always #2.5 clk = ~clk;

   dma_irq_agg #(.NUM_CH(NCH), .NUM_ERR(NER), .ADDR_W(8)) u_dma_irq_agg (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done(tx_done),
      .tx_ack(tx_ack), .rx_done(rx_done), .rx_ack(rx_ack),
      .err_done(err_done), .err_ack(err_ack), .irq_out(irq_out));

   typedef struct packed {
      logic        is_irq;
      logic [31:0] exp;
   } item_t;

   item_t exp_q[$];
   string tag_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done_run = 1'b0;

   // monitor: pops one expected item per cycle, away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         item_t it;
         string tg;
         logic [31:0] act;
         it  = exp_q.pop_front();
         tg  = tag_q.pop_front();
         act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tg, act, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tg);
      reg_addr = a;
      exp_q.push_back('{is_irq: 1'b0, exp: e});
      tag_q.push_back(tg);
      tick();
   endtask

   task automatic exp_irq(input logic e, input string tg);
      exp_q.push_back('{is_irq: 1'b1, exp: {31'b0, e}});
      tag_q.push_back(tg);
      tick();
   endtask

   initial begin
      #(200000 * 5);
      if (!done_run) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      exp_rd(8'h80, 32'h0, "R1 tx raw");
      exp_rd(8'hA8, 32'h0, "R1 rx mask");
      exp_rd(8'hB0, 32'h0, "R1 err raw");
      exp_rd(8'h90, 32'h0, "R1 vector");
      exp_irq(1'b0, "R1 irq");
      // R3 raw set by completion
      tx_done = 8'h05; tick(); tx_done = '0;
      exp_rd(8'h80, 32'h05, "R3 tx raw");
      exp_rd(8'h84, 32'h0,  "R7 masked with empty mask");
      exp_irq(1'b0, "R8 no enabled source");
      // R5 set
      wr(8'h88, 32'h04);
      exp_rd(8'h88, 32'h04, "R5 read at set addr");
      exp_rd(8'h8C, 32'h04, "R5 read at clear addr");
      exp_rd(8'h84, 32'h04, "R7 masked");
      exp_irq(1'b1, "R8 irq on");
      exp_rd(8'h90, 32'h1, "R10 vector tx");
      wr(8'h88, 32'h01);
      exp_rd(8'h88, 32'h05, "R5 zeros leave bits");
      // R6 clear
      wr(8'h8C, 32'h04);
      exp_rd(8'h88, 32'h01, "R6 clear one bit");
      exp_rd(8'h84, 32'h01, "R7 masked after clear");
      // R9 end of interrupt
      wr(8'h94, 32'hDEAD_BEEF);
      exp_irq(1'b0, "R9 gap cycle");
      exp_irq(1'b1, "R9 retrigger");
      // R4 ack and simultaneous
      tx_ack = 8'h01; tick(); tx_ack = '0;
      exp_rd(8'h80, 32'h04, "R4 ack clears");
      exp_irq(1'b0, "R8 off after ack");
      tx_done = 8'h02; tx_ack = 8'h02; tick(); tx_done = '0; tx_ack = '0;
      exp_rd(8'h80, 32'h06, "R4 set wins");
      // R6 all ones
      wr(8'h88, 32'hFF);
      wr(8'h8C, 32'hFFFF_FFFF);
      exp_rd(8'h88, 32'h0, "R6 all ones clear");
      exp_irq(1'b0, "R6 irq off");
      // R2 receive group
      rx_done = 8'h80; tick(); rx_done = '0;
      wr(8'hA8, 32'h80);
      exp_rd(8'hA4, 32'h80, "R2 rx masked");
      exp_rd(8'h90, 32'h2, "R10 vector rx");
      exp_irq(1'b1, "R2 rx irq");
      // R11 host error
      err_done = 2'b10; tick(); err_done = '0;
      exp_rd(8'hB0, 32'h2, "R11 err raw");
      wr(8'hB8, 32'h2);
      exp_rd(8'hB4, 32'h2, "R11 err masked");
      exp_rd(8'h90, 32'h6, "R10 vector rx+err");
      // R10 ignored writes
      wr(8'h80, 32'h0);
      exp_rd(8'h80, 32'h06, "R10 raw write ignored");
      wr(8'h90, 32'hFFFF);
      exp_rd(8'h90, 32'h6, "R10 vector write ignored");
      wr(8'hA4, 32'h0);
      exp_rd(8'hA0, 32'h80, "R10 masked write ignored");
      // R2 unmapped
      exp_rd(8'h40, 32'h0, "R2 unmapped");
      // R9 with two groups pending
      wr(8'h94, 32'h0);
      exp_irq(1'b0, "R9 gap again");
      exp_irq(1'b1, "R9 rearm");
      tick();
      done_run = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule